// File: doc/BRIEF.md
# Load Stride Prediction Table

This block watches the stream of load instructions and learns, for each load, whether it walks memory with a fixed step. Every load presents its program counter and effective address together with a valid strobe. The block keeps a small direct-mapped table. Each slot holds a tag, the last address seen, the last observed step and a two-bit confidence state. The slot is chosen by the low program-counter bits just above the instruction alignment.

On each access the block checks whether the new address equals the remembered address plus the remembered step. That outcome drives a four-state confidence machine: initial, transient, steady and no-prediction. It also decides whether the remembered step is overwritten with the newly observed one. When the access leaves the slot in the steady state with a non-zero step, the block asks for a prefetch of the current address plus the step. The request is a one-cycle pulse in the cycle after the access. Fetching the line and holding the result belong to the logic that consumes the request.

Top module: `stride_pref_predictor`

## Requirements
- R1: After reset no prefetch is requested and every slot is empty, so the first access to any slot counts as a miss.
- R2: The slot index is req_pc[ALIGN_BITS+IDX_W-1:ALIGN_BITS] (bits 5:2 with defaults) and the tag is every bit above it; an access whose tag differs from a filled slot's tag replaces that slot.
- R3: On a miss the slot is written with the new tag, previous address equal to req_addr, step zero and the initial state, and no prefetch is requested.
- R4: A prediction is correct exactly when req_addr equals the stored previous address plus the stored step, modulo 2^ADDR_W; on every access the previous address becomes req_addr, and a replaced step becomes req_addr minus the old previous address.
- R5: From initial, a correct access moves to steady and keeps the step; a wrong one moves to transient and replaces the step.
- R6: From transient, a correct access moves to steady and keeps the step; a wrong one moves to no-prediction and replaces the step.
- R7: From steady, a correct access stays in steady; a wrong one returns to initial and keeps the old step.
- R8: From no-prediction, a correct access moves to transient and keeps the step; a wrong one stays in no-prediction and replaces the step.
- R9: pf_valid is high in the cycle after an access that hits and leaves its slot in steady with a non-zero step, and pf_addr then equals req_addr plus that step; in all other cycles pf_valid is low.
- R10: A cycle with req_valid low changes no slot and requests no prefetch.
- R11: Address and step arithmetic wraps modulo 2^ADDR_W, so negative steps and steps that cross the top of the address space predict correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A load access is presented this cycle |
| req_pc | input | PC_W | Program counter of the load |
| req_addr | input | ADDR_W | Effective address of the load |
| pf_valid | output | 1 | One-cycle prefetch request strobe |
| pf_addr | output | ADDR_W | Address to prefetch, valid with pf_valid |

## Verification
Two functions overlap in one cycle here: the prefetch request registered from one access is on the output while the next access already rewrites a slot. That slot may be the same one, or a different program counter that aliases onto the same index. The bench provokes this with back-to-back accesses every cycle and with pairs of program counters that share an index but differ in tag, mixed into long pseudo-random streams of steps. Each cycle's pf_valid and pf_addr are compared with an arithmetic model of the table. The model must show that a reallocation never disturbs the request already issued and that the new access sees the slot as just written.

// File: rtl/spp_pkg.sv
// Shared types for the load stride prediction table.
// Assumes: the confidence state fits in two bits; the encoding is internal.
package spp_pkg;

    typedef enum logic [1:0] {
        CS_INIT   = 2'd0,
        CS_TRANS  = 2'd1,
        CS_STEADY = 2'd2,
        CS_NOPRED = 2'd3
    } conf_t;

endpackage

// File: rtl/spp_table.sv
// Storage of the direct-mapped prediction table.
// Each slot holds a fill flag, tag, previous address, step and confidence.
// Assumes: ENTRIES is a power of two; one read and one write port, the read
// is combinational and a write lands at the clock edge (no bypass needed,
// because the next access reads the slot after the edge).
module spp_table
    import spp_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 26,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_filled,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_prev,
    output logic [ADDR_W-1:0] rd_step,
    output conf_t             rd_conf,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_prev,
    input  logic [ADDR_W-1:0] wr_step,
    input  conf_t             wr_conf
);

    logic              filled_arr [ENTRIES];
    logic [TAG_W-1:0]  tag_arr    [ENTRIES];
    logic [ADDR_W-1:0] prev_arr   [ENTRIES];
    logic [ADDR_W-1:0] step_arr   [ENTRIES];
    conf_t             conf_arr   [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic              s_filled;
        logic [TAG_W-1:0]  s_tag;
        logic [ADDR_W-1:0] s_prev;
        logic [ADDR_W-1:0] s_step;
        conf_t             s_conf;
        logic              s_we;

        assign s_we = wr_en && (wr_idx == IDX_W'(e));

        // Slot register: cleared by reset, rewritten when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_filled <= 1'b0;
                s_tag    <= '0;
                s_prev   <= '0;
                s_step   <= '0;
                s_conf   <= CS_INIT;
            end else if (s_we) begin
                s_filled <= 1'b1;
                s_tag    <= wr_tag;
                s_prev   <= wr_prev;
                s_step   <= wr_step;
                s_conf   <= wr_conf;
            end
        end

        assign filled_arr[e] = s_filled;
        assign tag_arr[e]    = s_tag;
        assign prev_arr[e]   = s_prev;
        assign step_arr[e]   = s_step;
        assign conf_arr[e]   = s_conf;
    end

    assign rd_filled = filled_arr[rd_idx];
    assign rd_tag    = tag_arr[rd_idx];
    assign rd_prev   = prev_arr[rd_idx];
    assign rd_step   = step_arr[rd_idx];
    assign rd_conf   = conf_arr[rd_idx];

endmodule

// File: rtl/spp_update.sv
// Combinational evaluation of one access against the slot it indexes.
// Decides hit or miss, whether the step predicted the address, the new
// confidence and step to write back, and whether a prefetch is due.
// Assumes: all arithmetic wraps modulo 2^ADDR_W.
module spp_update
    import spp_pkg::*;
#(
    parameter int TAG_W  = 26,
    parameter int ADDR_W = 32
) (
    input  logic              ent_filled,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [ADDR_W-1:0] ent_prev,
    input  logic [ADDR_W-1:0] ent_step,
    input  conf_t             ent_conf,
    input  logic [TAG_W-1:0]  acc_tag,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              hit,
    output logic              correct,
    output logic [ADDR_W-1:0] new_step,
    output conf_t             new_conf,
    output logic              issue,
    output logic [ADDR_W-1:0] target
);

    logic [ADDR_W-1:0] seen_step;

    // Lookup and prediction test.
    always_comb begin
        hit       = ent_filled && (ent_tag == acc_tag);
        correct   = (acc_addr == ent_prev + ent_step);
        seen_step = acc_addr - ent_prev;
    end

    // Confidence machine and step replacement; a miss reallocates.
    always_comb begin
        new_step = ent_step;
        new_conf = ent_conf;
        if (!hit) begin
            new_step = '0;
            new_conf = CS_INIT;
        end else begin
            unique case (ent_conf)
                CS_INIT: begin
                    if (correct) new_conf = CS_STEADY;
                    else begin
                        new_conf = CS_TRANS;
                        new_step = seen_step;
                    end
                end
                CS_TRANS: begin
                    if (correct) new_conf = CS_STEADY;
                    else begin
                        new_conf = CS_NOPRED;
                        new_step = seen_step;
                    end
                end
                CS_STEADY: begin
                    new_conf = correct ? CS_STEADY : CS_INIT;
                end
                CS_NOPRED: begin
                    if (correct) new_conf = CS_TRANS;
                    else begin
                        new_conf = CS_NOPRED;
                        new_step = seen_step;
                    end
                end
                default: new_conf = CS_INIT;
            endcase
        end
    end

    // Prefetch decision from the state the slot is left in.
    always_comb begin
        issue  = hit && (new_conf == CS_STEADY) && (new_step != '0);
        target = acc_addr + new_step;
    end

endmodule

// File: rtl/stride_pref_predictor.sv
// Top of the load stride prediction table.
// Splits the program counter into index and tag, evaluates the access,
// writes the slot back and registers the prefetch request.
// Assumes: ALIGN_BITS >= 1, ENTRIES a power of two, PC_W > ALIGN_BITS+IDX_W.
module stride_pref_predictor
    import spp_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 16,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - ALIGN_BITS;

    logic [IDX_W-1:0]  acc_idx;
    logic [TAG_W-1:0]  acc_tag;
    logic              unused_align;

    logic              ent_filled;
    logic [TAG_W-1:0]  ent_tag;
    logic [ADDR_W-1:0] ent_prev;
    logic [ADDR_W-1:0] ent_step;
    conf_t             ent_conf;

    logic              lookup_hit;
    logic              pred_correct;
    logic [ADDR_W-1:0] wb_step;
    conf_t             wb_conf;
    logic              pf_issue;
    logic [ADDR_W-1:0] pf_target;

    // Field split of the program counter.
    assign acc_idx      = req_pc[ALIGN_BITS +: IDX_W];
    assign acc_tag      = req_pc[PC_W-1 -: TAG_W];
    assign unused_align = ^req_pc[ALIGN_BITS-1:0];

    spp_table #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .ADDR_W  (ADDR_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (acc_idx),
        .rd_filled (ent_filled),
        .rd_tag    (ent_tag),
        .rd_prev   (ent_prev),
        .rd_step   (ent_step),
        .rd_conf   (ent_conf),
        .wr_en     (req_valid),
        .wr_idx    (acc_idx),
        .wr_tag    (acc_tag),
        .wr_prev   (req_addr),
        .wr_step   (wb_step),
        .wr_conf   (wb_conf)
    );

    spp_update #(
        .TAG_W  (TAG_W),
        .ADDR_W (ADDR_W)
    ) u_update (
        .ent_filled (ent_filled),
        .ent_tag    (ent_tag),
        .ent_prev   (ent_prev),
        .ent_step   (ent_step),
        .ent_conf   (ent_conf),
        .acc_tag    (acc_tag),
        .acc_addr   (req_addr),
        .hit        (lookup_hit),
        .correct    (pred_correct),
        .new_step   (wb_step),
        .new_conf   (wb_conf),
        .issue      (pf_issue),
        .target     (pf_target)
    );

    // Prefetch request register: one pulse per qualifying access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= req_valid && pf_issue;
            if (req_valid && pf_issue) pf_addr <= pf_target;
        end
    end

endmodule

// File: rtl/spp_checker.sv
// Temporal checks on the stride prediction table, bound to its top.
// Assumes: rst_n is driven to a known level from time zero.
module spp_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              lookup_hit,
    input logic              pred_correct,
    input logic              pf_valid,
    input logic [ADDR_W-1:0] pf_addr
);

    // R1: a reset cycle leaves no request behind it.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !pf_valid);

    // R10: an idle cycle never produces a request.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !pf_valid);

    // R3: a miss reallocates and never requests.
    a_r3_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !lookup_hit) |=> !pf_valid);

    // R5..R8: a wrong prediction never leaves the slot in steady.
    a_r7_wrong_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lookup_hit && !pred_correct) |=> !pf_valid);

    // R9: a request always points away from the access, the step being non-zero.
    a_r9_nonzero_step: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!pf_valid || (pf_addr != $past(req_addr))));

endmodule

bind stride_pref_predictor spp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .lookup_hit   (lookup_hit),
    .pred_correct (pred_correct),
    .pf_valid     (pf_valid),
    .pf_addr      (pf_addr)
);

// File: tb/tb_stride_pref_predictor.sv
`timescale 1ns/1ps
// Bench for the stride prediction table at default parameters
// (16 slots, index = pc[5:2], tag = pc[31:6]). An arithmetic model of the
// table, written from the requirements, predicts every output cycle.
module tb_stride_pref_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_pc = '0;
    logic [31:0] req_addr = '0;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    stride_pref_predictor dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_pc    (req_pc),
        .req_addr  (req_addr),
        .pf_valid  (pf_valid),
        .pf_addr   (pf_addr)
    );

    // Model state: 0 initial, 1 transient, 2 steady, 3 no-prediction.
    logic        m_filled [16];
    logic [25:0] m_tag    [16];
    logic [31:0] m_prev   [16];
    logic [31:0] m_step   [16];
    int          m_conf   [16];

    task automatic model_step(input logic v, input logic [31:0] pc,
                              input logic [31:0] addr, output logic ev,
                              output logic [31:0] ea, output string t);
        int          i;
        logic [25:0] tg;
        logic        ok;
        logic [31:0] seen;
        i  = int'(pc[5:2]);
        tg = pc[31:6];
        ev = 1'b0;
        ea = '0;
        if (!v) begin
            t = "R10";
            return;
        end
        if (!m_filled[i] || m_tag[i] != tg) begin
            t = m_filled[i] ? "R2" : "R3";
            m_filled[i] = 1'b1;
            m_tag[i]    = tg;
            m_prev[i]   = addr;
            m_step[i]   = '0;
            m_conf[i]   = 0;
            return;
        end
        ok   = (addr == m_prev[i] + m_step[i]);
        seen = addr - m_prev[i];
        case (m_conf[i])
            0: begin t = "R5"; if (ok) m_conf[i] = 2; else begin m_conf[i] = 1; m_step[i] = seen; end end
            1: begin t = "R6"; if (ok) m_conf[i] = 2; else begin m_conf[i] = 3; m_step[i] = seen; end end
            2: begin t = "R7"; if (!ok) m_conf[i] = 0; end
            default: begin t = "R8"; if (ok) m_conf[i] = 1; else m_step[i] = seen; end
        endcase
        m_prev[i] = addr;
        ev = (m_conf[i] == 2) && (m_step[i] != 0);
        ea = addr + m_step[i];
    endtask

    // Present one cycle of stimulus and check the registered response.
    task automatic access(input logic v, input logic [31:0] pc,
                          input logic [31:0] addr, input string force_tag);
        logic        ev;
        logic [31:0] ea;
        string       t;
        model_step(v, pc, addr, ev, ea, t);
        if (force_tag != "") t = force_tag;
        req_valid = v;
        req_pc    = pc;
        req_addr  = addr;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (pf_valid !== ev) begin
            errors++;
            $display("FAIL %s pf_valid actual=%0b expected=%0b (pc=%h addr=%h)",
                     t, pf_valid, ev, pc, addr);
        end
        if (ev) begin
            checks++;
            if (pf_addr !== ea) begin
                errors++;
                $display("FAIL %s pf_addr actual=%h expected=%h",
                         (force_tag != "") ? force_tag : "R9", pf_addr, ea);
            end
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] lcg;
        logic [31:0] cur  [4];
        logic [31:0] stp  [4];
        logic [31:0] pcs  [4];
        logic [31:0] menu [6];

        for (int i = 0; i < 16; i++) begin
            m_filled[i] = 1'b0; m_tag[i] = '0; m_prev[i] = '0;
            m_step[i] = '0; m_conf[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the output.
        checks++;
        if (pf_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 pf_valid after reset actual=%0b expected=0", pf_valid);
        end

        // R1: every slot starts empty; a sweep of all indexes must miss.
        for (int i = 0; i < 16; i++)
            access(1'b1, 32'h4000_0000 | (i << 2), 32'h1000 + i * 64, "R1");

        // R4: detect a step, then confirm it.
        access(1'b1, 32'h0000_2040, 32'd100, "");
        access(1'b1, 32'h0000_2040, 32'd108, "");
        access(1'b1, 32'h0000_2040, 32'd116, "R4");

        // R11: step crossing the top of the address space, and a negative step.
        access(1'b1, 32'h0000_3044, 32'hFFFF_FFF0, "");
        access(1'b1, 32'h0000_3044, 32'hFFFF_FFF8, "");
        access(1'b1, 32'h0000_3044, 32'h0000_0000, "R11");
        access(1'b1, 32'h0000_3048, 32'h0000_0010, "");
        access(1'b1, 32'h0000_3048, 32'h0000_0008, "");
        access(1'b1, 32'h0000_3048, 32'h0000_0000, "R11");

        // R7 then R5: steady falls to initial keeping the step, then recovers.
        access(1'b1, 32'h0000_2040, 32'd500, "R7");
        access(1'b1, 32'h0000_2040, 32'd508, "R5");

        // R10: idle cycles, then the slot must still be intact.
        for (int k = 0; k < 4; k++) access(1'b0, 32'h0000_2040, 32'd999, "R10");
        access(1'b1, 32'h0000_2040, 32'd516, "R10");

        // R2: alias on the same index replaces the slot; original returns as a miss.
        access(1'b1, 32'h0001_2040, 32'd516, "R2");
        access(1'b1, 32'h0000_2040, 32'd524, "R2");

        // Exhaustive sweep: every slot, every step from a small menu.
        menu[0] = 32'd4; menu[1] = 32'hFFFF_FFF8; menu[2] = 32'd64;
        menu[3] = 32'd0; menu[4] = 32'd12; menu[5] = 32'hFFFF_FF00;
        for (int i = 0; i < 16; i++)
            for (int s = 0; s < 6; s++)
                for (int n = 0; n < 5; n++)
                    access(1'b1, 32'h0800_0000 | (i << 2), 32'h7000_0000 + n * menu[s], "");

        // Back-to-back mixed streams with aliasing program counters.
        pcs[0] = 32'h0000_1004; pcs[1] = 32'h0040_1004;
        pcs[2] = 32'h0000_1008; pcs[3] = 32'h0000_1014;
        for (int s = 0; s < 4; s++) begin
            cur[s] = 32'h2000_0000 * s;
            stp[s] = menu[s];
        end
        lcg = 32'h1234_5678;
        for (int n = 0; n < 6000; n++) begin
            int sl;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            sl  = int'(lcg[17:16]);
            if (lcg[27:25] == 3'd0) stp[sl] = menu[lcg[30:28] % 6];
            if (lcg[23:20] == 4'd0) cur[sl] = cur[sl] ^ {lcg[15:0], 16'h0};
            if (lcg[9:6] == 4'd1) begin
                access(1'b0, pcs[sl], cur[sl], "");
            end else begin
                cur[sl] = cur[sl] + stp[sl];
                access(1'b1, pcs[sl], cur[sl], "");
            end
        end

        req_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule